// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

A first-in first-out buffer that holds 36-bit entries and has separate write and read clocks. Each port can run 36, 18 or 9 bits wide. A wide producer can feed a narrow consumer, and a narrow producer can feed a wide consumer. Narrow words are packed into 36-bit entries, or unpacked from them, in a byte order chosen at master reset.

The port widths, the byte order, the output timing style and the update style of the two almost flags are all captured while master reset is held low. The output timing style is either registered reads with empty/full flags, or first-word fall-through with output-ready/input-ready flags. The two almost thresholds reset to 7 entries and can be reloaded with a strobe. There are two resets. A partial reset throws away the stored data but keeps the thresholds and the configuration. Retransmit sends the read side back to the first entry written since the last reset.

Top module: `bm_fifo`

## Requirements
- R1: The select inputs `in_sel`, `out_sel`, `big_end`, `fwft_sel`, `ae_async` and `af_async` are sampled only on write-clock edges while `mrst_n` is low. Changes to them after master reset is released have no effect.
- R2: Width code 0 selects 36 bits, 1 selects 18 bits, and 2 or 3 select 9 bits. A narrow word travels on bits [W-1:0] of `din` or `dout`, and the upper `dout` bits read 0. Lanes are numbered k = 0, 1, ... in arrival order. With `big_end`=1, lane k occupies bit offset (n-1-k)·W of the entry; with `big_end`=0 it occupies offset k·W, where n = 36/W.
- R3: When the write side is narrow (18 or 9 bits), the read side runs 36 bits wide whatever `out_sel` is.
- R4: An entry becomes readable only after its last write lane has been accepted. The read side stays non-empty until the last lane of the head entry has been read.
- R5: In standard mode (`fwft_sel`=0), `in_flag` is full and `out_flag` is empty. The lane read at a read-clock edge with `ren`=1 appears on `dout` after that edge.
- R6: In fall-through mode (`fwft_sel`=1), `in_flag` means ready for input and `out_flag` means output available. The head lane is on `dout` with no read request, and `ren` moves to the next lane.
- R7: A write while 2^AW entries are stored is ignored. A read while empty is ignored and leaves `dout` unchanged.
- R8: `almost_empty` is 1 when the stored entries are at most the empty threshold. `almost_full` is 1 when the stored entries are at least 2^AW minus the full threshold.
- R9: `ld`=1 at a write-clock edge loads the empty threshold from `ae_val` and the full threshold from `af_val`.
- R10: In synchronous almost mode (`ae_async` or `af_async` = 0), a flag is registered from the synchronized pointer and lags the far clock by several cycles. In asynchronous mode it follows both raw pointers and changes within the same clock phase.
- R11: Partial reset (`prst_n` low) empties the FIFO and clears lane state, but keeps the thresholds and the configuration.
- R12: Master reset empties the FIFO and sets both thresholds to 7. After release, `almost_empty`=1 and `almost_full`=0, and the flags report empty and not full.
- R13: `rtx`=1 at a read-clock edge returns reading to lane 0 of the first entry written since the last reset. A `ren` in the same edge is ignored. Following reads replay the data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| in_sel | input | 2 | Write width code, sampled in master reset |
| out_sel | input | 2 | Read width code, sampled in master reset |
| big_end | input | 1 | 1: first lane in the high bits |
| fwft_sel | input | 1 | 1: fall-through timing |
| ae_async | input | 1 | 1: asynchronous almost-empty |
| af_async | input | 1 | 1: asynchronous almost-full |
| ld | input | 1 | Threshold load strobe (write clock) |
| ae_val | input | AW+1 | New almost-empty threshold |
| af_val | input | AW+1 | New almost-full threshold |
| wen | input | 1 | Write request |
| din | input | 36 | Write data |
| in_flag | output | 1 | Full, or input ready in fall-through mode |
| almost_full | output | 1 | Almost-full flag |
| ren | input | 1 | Read request |
| rtx | input | 1 | Retransmit request |
| dout | output | 36 | Read data |
| out_flag | output | 1 | Empty, or output ready in fall-through mode |
| almost_empty | output | 1 | Almost-empty flag |

## Verification
Retransmit and a read request can land on the same read-clock edge. The bench drives `rtx` and `ren` high together after part of the data has been drained. It judges the outcome in two ways: `dout` must keep its last lane, and the next reads must replay the stream from the first entry. A second collision is the commit of the final lane of an entry against the flag logic. The bench checks the synchronous almost flag half a cycle after that commit, expecting the old value, then checks it again once the pointers settle. It makes the same check in asynchronous mode, expecting the new value at once.

// File: rtl/bm_fifo.sv
`timescale 1ns/1ps
module bm_fifo #(
  parameter int AW      = 4,
  parameter int OFF_DEF = 7
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        mrst_n,
  input  logic        prst_n,
  input  logic [1:0]  in_sel,
  input  logic [1:0]  out_sel,
  input  logic        big_end,
  input  logic        fwft_sel,
  input  logic        ae_async,
  input  logic        af_async,
  input  logic        ld,
  input  logic [AW:0] ae_val,
  input  logic [AW:0] af_val,
  input  logic        wen,
  input  logic [35:0] din,
  output logic        in_flag,
  output logic        almost_full,
  input  logic        ren,
  input  logic        rtx,
  output logic [35:0] dout,
  output logic        out_flag,
  output logic        almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEP = (AW+1)'(DEPTH);

  logic [1:0]  isel_q, osel_q, wlane, rlane;
  logic        be_q, fwft_q, aea_q, afa_q;
  logic [AW:0] ae_off, af_off;
  logic [35:0] mem [DEPTH];
  logic [AW:0] wptr, rptr, wq1, wq2, rq1, rq2, wcnt, rcnt, acnt;
  logic [35:0] wentry, rword, dreg;
  logic        full, empty, af_q, ae_q, wdo, wlast, rdo, rlast;
  int          wn, rn, ww, rw, wpos, rpos;
  wire         clr_n = mrst_n & prst_n;

  function automatic int lanes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [35:0] lmask(input int w);
    return (36'h1 << w) - 36'h1;
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge wclk)
    if (!mrst_n) {isel_q, osel_q, be_q, fwft_q, aea_q, afa_q} <=
                 {in_sel, out_sel, big_end, fwft_sel, ae_async, af_async};

  always_ff @(posedge wclk or negedge mrst_n)
    if (!mrst_n) begin
      ae_off <= (AW+1)'(OFF_DEF);
      af_off <= (AW+1)'(OFF_DEF);
    end else if (ld) begin
      ae_off <= ae_val;
      af_off <= af_val;
    end

  always_comb begin
    wn   = lanes(isel_q);
    rn   = (wn == 1) ? lanes(osel_q) : 1;
    ww   = 36 / wn;
    rw   = 36 / rn;
    wpos = be_q ? (wn - 1 - int'(wlane)) * ww : int'(wlane) * ww;
    rpos = be_q ? (rn - 1 - int'(rlane)) * rw : int'(rlane) * rw;
  end

  logic [35:0] wpack;
  assign wentry = (wpack & ~(lmask(ww) << wpos)) | ((din & lmask(ww)) << wpos);
  assign rword  = (mem[rptr[AW-1:0]] >> rpos) & lmask(rw);

  assign wcnt  = wptr - g2b(rq2);
  assign rcnt  = g2b(wq2) - rptr;
  assign acnt  = wptr - rptr;
  assign full  = (wcnt == DEP);
  assign empty = (rcnt == '0);
  assign wdo   = wen & ~full;
  assign wlast = (int'(wlane) == wn - 1);
  assign rdo   = ren & ~empty & ~rtx;
  assign rlast = (int'(rlane) == rn - 1);

  always_ff @(posedge wclk)
    if (wdo && wlast) mem[wptr[AW-1:0]] <= wentry;

  always_ff @(posedge wclk or negedge clr_n)
    if (!clr_n) begin
      wptr <= '0; wlane <= '0; wpack <= '0;
      rq1 <= '0; rq2 <= '0; af_q <= 1'b0;
    end else begin
      rq1  <= rptr ^ (rptr >> 1);
      rq2  <= rq1;
      af_q <= (wcnt >= DEP - af_off);
      if (wdo) begin
        wpack <= wentry;
        wlane <= wlast ? 2'd0 : wlane + 2'd1;
        if (wlast) wptr <= wptr + 1'b1;
      end
    end

  always_ff @(posedge rclk or negedge clr_n)
    if (!clr_n) begin
      rptr <= '0; rlane <= '0; dreg <= '0;
      wq1 <= '0; wq2 <= '0; ae_q <= 1'b1;
    end else begin
      wq1  <= wptr ^ (wptr >> 1);
      wq2  <= wq1;
      ae_q <= (rcnt <= ae_off);
      if (rtx) begin
        rptr  <= '0;
        rlane <= '0;
      end else if (rdo) begin
        dreg  <= rword;
        rlane <= rlast ? 2'd0 : rlane + 2'd1;
        if (rlast) rptr <= rptr + 1'b1;
      end
    end

  assign almost_full  = afa_q ? (acnt >= DEP - af_off) : af_q;
  assign almost_empty = aea_q ? (acnt <= ae_off) : ae_q;
  assign in_flag      = fwft_q ? ~full : full;
  assign out_flag     = fwft_q ? ~empty : empty;
  assign dout         = fwft_q ? rword : dreg;
endmodule

// File: rtl/bm_fifo_chk.sv
`timescale 1ns/1ps
module bm_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        clr_n,
  input logic        wen,
  input logic        rtx,
  input logic        full,
  input logic        empty,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr,
  input logic [AW:0] wcnt,
  input logic [1:0]  wlane,
  input logic [1:0]  rlane,
  input int          wn
);
  localparam logic [AW:0] DEP = (AW+1)'(1 << AW);

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!clr_n)
    wcnt <= DEP); // R7
  AST_FULL_HOLD: assert property (@(posedge wclk) disable iff (!clr_n)
    (full && wen) |=> ($stable(wptr) && $stable(wlane))); // R7
  AST_EMPTY_HOLD: assert property (@(posedge rclk) disable iff (!clr_n)
    (empty && !rtx) |=> ($stable(rptr) && $stable(rlane))); // R7
  AST_RTX_HOME: assert property (@(posedge rclk) disable iff (!clr_n)
    rtx |=> (rptr == '0 && rlane == 2'd0)); // R13
  AST_COMMIT_LAST: assert property (@(posedge wclk) disable iff (!clr_n)
    (wptr != $past(wptr)) |-> (int'($past(wlane)) == wn - 1)); // R4
endmodule

bind bm_fifo bm_fifo_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_bm_fifo.sv
`timescale 1ns/1ps
module sim_bm_fifo;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, mrst_n = 0, prst_n = 1;
  logic [1:0] in_sel = 0, out_sel = 0;
  logic big_end = 0, fwft_sel = 0, ae_async = 0, af_async = 0, ld = 0;
  logic [AW:0] ae_val = 0, af_val = 0;
  logic wen = 0, ren = 0, rtx = 0;
  logic [35:0] din = 0;
  logic in_flag, almost_full, out_flag, almost_empty;
  logic [35:0] dout;

  always #2.5 wclk = ~wclk;
  always #2.5 rclk = ~rclk;

  bm_fifo #(.AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .in_sel(in_sel), .out_sel(out_sel), .big_end(big_end), .fwft_sel(fwft_sel),
    .ae_async(ae_async), .af_async(af_async), .ld(ld), .ae_val(ae_val), .af_val(af_val),
    .wen(wen), .din(din), .in_flag(in_flag), .almost_full(almost_full),
    .ren(ren), .rtx(rtx), .dout(dout), .out_flag(out_flag), .almost_empty(almost_empty));

  int nchk = 0, nfail = 0;
  logic [35:0] q[$], hist[$], lb[$];
  int mwn = 1, mrn = 1, mw = 36, mrw = 36, rl = 0, aeo = 7, afo = 7;
  bit mbe = 0, mfwft = 0;

  function automatic int lanes_of(int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [35:0] msk(int w);
    return (36'h1 << w) - 36'h1;
  endfunction

  function automatic logic [35:0] w36(int i);
    return {4'(i), 32'(i) * 32'h9E3779B1};
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge rclk) begin
    #1;
    if (mrst_n && prst_n && q.size() == 0)
      chk("R7 monitor out_flag", 36'(out_flag), mfwft ? 36'h0 : 36'h1);
  end

  task automatic mreset(int is, int os, bit be, bit fw, bit aea, bit afa);
    @(negedge wclk);
    in_sel = 2'(is); out_sel = 2'(os); big_end = be; fwft_sel = fw;
    ae_async = aea; af_async = afa; mrst_n = 0;
    repeat (3) @(negedge wclk);
    mrst_n = 1;
    mwn = lanes_of(is); mrn = (mwn == 1) ? lanes_of(os) : 1;
    mw = 36 / mwn; mrw = 36 / mrn; mbe = be; mfwft = fw;
    q.delete(); hist.delete(); lb.delete(); rl = 0; aeo = 7; afo = 7;
    in_sel = ~in_sel; out_sel = ~out_sel; big_end = ~be; fwft_sel = ~fw;
    ae_async = ~aea; af_async = ~afa;
  endtask

  task automatic push(logic [35:0] v);
    logic [35:0] e;
    wen = 1; din = v;
    @(negedge wclk);
    wen = 0;
    if (q.size() < DEPTH) begin
      lb.push_back(v & msk(mw));
      if (lb.size() == mwn) begin
        e = '0;
        for (int k = 0; k < mwn; k++)
          e |= lb[k] << (mbe ? (mwn - 1 - k) * mw : k * mw);
        q.push_back(e); hist.push_back(e); lb.delete();
      end
    end
  endtask

  task automatic pull(string req);
    logic [35:0] e;
    e = (q[0] >> (mbe ? (mrn - 1 - rl) * mrw : rl * mrw)) & msk(mrw);
    if (mfwft) chk(req, dout, e);
    ren = 1;
    @(negedge wclk);
    ren = 0;
    if (!mfwft) chk(req, dout, e);
    rl++;
    if (rl == mrn) begin rl = 0; void'(q.pop_front()); end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
  endtask

  task automatic flags(string req);
    int c;
    bit fe, ee;
    settle();
    c = q.size(); fe = (c == DEPTH); ee = (c == 0);
    chk({req, " in_flag"}, 36'(in_flag), 36'(mfwft ? !fe : fe));
    chk({req, " out_flag"}, 36'(out_flag), 36'(mfwft ? !ee : ee));
    chk({req, " almost_empty"}, 36'(almost_empty), 36'(c <= aeo));
    chk({req, " almost_full"}, 36'(almost_full), 36'(c >= DEPTH - afo));
  endtask

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [35:0] prev;
    // standard 36/36
    mreset(0, 0, 0, 0, 0, 0);
    @(negedge wclk);
    chk("R12 reset out_flag", 36'(out_flag), 36'h1);
    chk("R12 reset in_flag", 36'(in_flag), 36'h0);
    chk("R12 reset almost_empty", 36'(almost_empty), 36'h1);
    chk("R12 reset almost_full", 36'(almost_full), 36'h0);
    for (int i = 0; i < 7; i++) push(w36(i));
    flags("R8 seven");
    push(w36(7));
    chk("R10 sync lag almost_empty", 36'(almost_empty), 36'h1);
    flags("R8 eight");
    push(w36(8)); push(w36(9));
    flags("R8 ten");
    for (int i = 0; i < 10; i++) pull("R5 data");
    flags("R5 drained");
    for (int i = 20; i < 36; i++) push(w36(i));
    flags("R7 full");
    push(w36(99));
    for (int i = 0; i < 16; i++) pull("R7 data after overflow");
    flags("R7 empty");
    prev = dout;
    ren = 1; @(negedge wclk); ren = 0;
    chk("R7 read while empty", dout, prev);
    flags("R7 after empty read");

    // threshold load and partial reset
    ld = 1; ae_val = 2; af_val = 3;
    @(negedge wclk);
    ld = 0; aeo = 2; afo = 3;
    for (int i = 0; i < 5; i++) push(w36(40 + i));
    prst_n = 0;
    repeat (2) @(negedge wclk);
    prst_n = 1;
    q.delete(); hist.delete(); lb.delete(); rl = 0;
    flags("R11 after partial reset");
    push(w36(50)); push(w36(51));
    flags("R9 two");
    push(w36(52));
    flags("R9 three");
    for (int i = 0; i < 9; i++) push(w36(53 + i));
    flags("R9 twelve");
    push(w36(70));
    flags("R9 thirteen");

    // 36 -> 9 big-endian, thresholds back to defaults
    mreset(0, 2, 1, 0, 0, 0);
    flags("R12 defaults restored");
    for (int i = 0; i < 7; i++) push(w36(80 + i));
    flags("R12 seven");
    push(w36(87));
    flags("R12 eight");
    for (int i = 0; i < 32; i++) pull("R1 R2 unpack 9 big");
    push(w36(90));
    settle();
    for (int i = 0; i < 3; i++) pull("R2 unpack 9 big");
    flags("R4 partly read entry");
    pull("R2 last lane");
    flags("R4 entry done");

    // 9 -> 36 little-endian
    mreset(2, 0, 0, 0, 0, 0);
    push(36'h1A1); push(36'h0B2); push(36'h1C3);
    flags("R4 partial entry hidden");
    push(36'h0D4);
    flags("R4 entry committed");
    pull("R2 pack 9 little");
    for (int i = 0; i < 8; i++) push(36'(9'h100 + 9'(i * 37)));
    settle();
    pull("R2 pack 9 little"); pull("R2 pack 9 little");

    // 18 in with 9 requested out -> 36 out, big-endian
    mreset(1, 2, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) push(36'(18'h2A5C3 + 18'(i * 4099)));
    settle();
    pull("R3 forced wide out"); pull("R3 forced wide out");

    // 36 -> 18 little-endian, fall-through
    mreset(0, 1, 0, 1, 0, 0);
    @(negedge wclk);
    chk("R6 reset in_flag", 36'(in_flag), 36'h1);
    chk("R6 reset out_flag", 36'(out_flag), 36'h0);
    push(w36(100)); push(w36(101));
    flags("R6 two stored");
    for (int i = 0; i < 4; i++) pull("R6 fall-through data");
    flags("R6 drained");

    // retransmit with simultaneous read
    mreset(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) push(w36(110 + i));
    settle();
    pull("R13 first pass"); pull("R13 first pass");
    prev = dout;
    rtx = 1; ren = 1;
    @(negedge wclk);
    rtx = 0; ren = 0;
    q = hist; rl = 0;
    chk("R13 read ignored with retransmit", dout, prev);
    for (int i = 0; i < 4; i++) pull("R13 replay");
    flags("R13 replay drained");

    // asynchronous almost flags
    mreset(0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 7; i++) push(w36(120 + i));
    settle();
    push(w36(127));
    chk("R10 async almost_empty", 36'(almost_empty), 36'h0);
    push(w36(128));
    chk("R10 async almost_full", 36'(almost_full), 36'h1);
    flags("R10 settled");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule